// File: doc/BRIEF.md
# Configurable Logic Cell

This block is a small logic cell whose function is set at run time. Four lane selectors each take one line from a 32-line signal pool. Each of the four chosen signals feeds all four gate stages. A gate stage ORs together any mix of true and complemented lane terms and can invert its result. A 3-bit mode field picks how the four gate outputs combine. Three modes are purely combinational. Five modes keep one bit of state: a latch or a flip-flop.

The combined result can be inverted, and it can be forced low by a cell enable. It is offered to a pin path that only carries the value when the pin enable is set. Rising and falling transitions of the cell output can each be armed to set a sticky interrupt flag. A synchronous clear input drops the flag. Every configuration field is a plain input sampled on the system clock. The flip-flop modes use gate 1 as a clock-enable edge, so nothing leaves the system clock domain.

Top module: `cfg_logic_cell`

## Requirements
- R1: Lane k (k = 0..3) carries `pool_in[src_sel[5k+4:5k]]`, i.e. the pool line whose index is that lane's 5-bit select field.
- R2: Gate g (g = 0..3) outputs the OR of lane k where `gate_true[4g+k]` is set and of NOT lane k where `gate_comp[4g+k]` is set, XORed with `gate_inv[g]`. Gates 1..4 of the following requirements are gates 0..3.
- R3: Mode 000 gives (g1 AND g2) OR (g3 AND g4). Mode 001 gives (g1 OR g2) XOR (g3 OR g4). Mode 010 gives the AND of all four gates. All three reach the output in the same cycle.
- R4: Mode 011 is a set/reset latch, set by g1 OR g2 and reset by g3 OR g4, with set winning. It updates at each clock edge, and the output shows the stored bit.
- R5: In mode 100 the stored bit is cleared by g3, else set by g4, else loaded with g2 on a rising edge of g1. In mode 101 it is cleared by g3, else loaded with g2 XOR g4 on a rising edge of g1. A rising edge of g1 means g1 is high now and was low at the previous clock.
- R6: Mode 110 is a JK flip-flop cleared by g3. Otherwise, on a rising edge of g1, J=g2 and K=g4 give hold (00), set (10), clear (01) or toggle (11).
- R7: Mode 111 is a transparent latch. It is cleared by g3, else set by g4, else it takes g2 at every clock while g1 is high.
- R8: With `cell_en` high, `cell_out` is the mode result XOR `out_pol`. With `cell_en` low, `cell_out` is 0 and the stored bit does not change.
- R9: `pin_out` equals `cell_out` when `pin_oe` is 1 and is 0 otherwise.
- R10: A 0-to-1 change of `cell_out` between consecutive clocks with `rise_ie` set, or a 1-to-0 change with `fall_ie` set, makes `irq_flag` high from the next cycle on. The flag stays high until a clock with `flag_clr` high, which clears it; the clear wins over a same-cycle edge.
- R11: Synchronous reset clears the stored bit, the gate-1 and output history and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pool_in | input | 32 | Signal pool |
| src_sel | input | 20 | Four 5-bit lane selects, lane k at bits 5k+4:5k |
| gate_true | input | 16 | True-term enables, gate g lane k at bit 4g+k |
| gate_comp | input | 16 | Complement-term enables, same layout |
| gate_inv | input | 4 | Per-gate output inversion |
| mode | input | 3 | Logic function select |
| cell_en | input | 1 | Cell enable |
| out_pol | input | 1 | Output inversion |
| pin_oe | input | 1 | Pin output enable |
| rise_ie | input | 1 | Rising-edge flag enable |
| fall_ie | input | 1 | Falling-edge flag enable |
| flag_clr | input | 1 | Synchronous flag clear |
| cell_out | output | 1 | Cell output |
| pin_out | output | 1 | Pin-side output, low when not enabled |
| irq_flag | output | 1 | Sticky edge flag |

## Verification
The bench drives every lane select across all 32 pool lines, so a wrong index or a wrong lane order would show as a stuck or misrouted output. Long random runs switch modes while state is held. A design that took the flip-flop edge from the level of g1, or that gave set and reset the wrong priority, would drift from the model within a few cycles. Disabled cycles under inverted polarity show whether the enable gates the output after polarity and freezes the stored bit. Clears that land on the same cycle as an armed edge catch a flag that lets set win over clear.

// File: rtl/clc_pkg.sv
package clc_pkg;
    localparam int LANES  = 4;
    localparam int POOL_W = 32;

    typedef enum logic [2:0] {
        MD_ANDOR    = 3'd0,
        MD_ORXOR    = 3'd1,
        MD_AND4     = 3'd2,
        MD_SR       = 3'd3,
        MD_DFF_SR   = 3'd4,
        MD_DFF2_R   = 3'd5,
        MD_JK_R     = 3'd6,
        MD_LATCH_SR = 3'd7
    } mode_e;

    typedef logic [LANES-1:0] lane_t;

    typedef struct packed {
        lane_t true_en;
        lane_t comp_en;
        logic  inv;
    } gate_cfg_t;

    function automatic logic gate_eval(gate_cfg_t c, lane_t d);
        return ((|(c.true_en & d)) | (|(c.comp_en & ~d))) ^ c.inv;
    endfunction

    function automatic logic is_stateful(mode_e m);
        return (m == MD_SR) || (m == MD_DFF_SR) || (m == MD_DFF2_R) ||
               (m == MD_JK_R) || (m == MD_LATCH_SR);
    endfunction
endpackage

// File: rtl/clc_src_mux.sv
module clc_src_mux
    import clc_pkg::*;
#(
    parameter int POOL = POOL_W,
    localparam int SW  = $clog2(POOL)
) (
    input  logic [POOL-1:0]     pool_in,
    input  logic [LANES*SW-1:0] src_sel,
    output lane_t               lane_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SW-1:0] idx;
        assign idx       = src_sel[k*SW +: SW];
        assign lane_o[k] = pool_in[idx];
    end
endmodule

// File: rtl/clc_gate_bank.sv
module clc_gate_bank
    import clc_pkg::*;
(
    input  lane_t                 lane_i,
    input  logic [LANES*LANES-1:0] gate_true,
    input  logic [LANES*LANES-1:0] gate_comp,
    input  lane_t                 gate_inv,
    output lane_t                 gate_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_gate
        gate_cfg_t cfg;
        assign cfg.true_en = gate_true[g*LANES +: LANES];
        assign cfg.comp_en = gate_comp[g*LANES +: LANES];
        assign cfg.inv     = gate_inv[g];
        assign gate_o[g]   = gate_eval(cfg, lane_i);
    end
endmodule

// File: rtl/clc_func_core.sv
module clc_func_core
    import clc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode,
    input  lane_t      gate_i,
    input  logic       en,
    output logic       fn_o,
    output logic       q_o
);
    mode_e m;
    logic  q, q_next, g1_prev, g1_rise;
    logic  sr_set, sr_clr;

    assign m       = mode_e'(mode);
    assign g1_rise = gate_i[0] & ~g1_prev;
    assign sr_set  = gate_i[0] | gate_i[1];
    assign sr_clr  = gate_i[2] | gate_i[3];

    always_comb begin
        q_next = q;
        unique case (m)
            MD_SR: begin
                if (sr_set)      q_next = 1'b1;
                else if (sr_clr) q_next = 1'b0;
            end
            MD_DFF_SR: begin
                if (gate_i[2])      q_next = 1'b0;
                else if (gate_i[3]) q_next = 1'b1;
                else if (g1_rise)   q_next = gate_i[1];
            end
            MD_DFF2_R: begin
                if (gate_i[2])    q_next = 1'b0;
                else if (g1_rise) q_next = gate_i[1] ^ gate_i[3];
            end
            MD_JK_R: begin
                if (gate_i[2]) q_next = 1'b0;
                else if (g1_rise) begin
                    unique case ({gate_i[1], gate_i[3]})
                        2'b10:   q_next = 1'b1;
                        2'b01:   q_next = 1'b0;
                        2'b11:   q_next = ~q;
                        default: q_next = q;
                    endcase
                end
            end
            MD_LATCH_SR: begin
                if (gate_i[2])      q_next = 1'b0;
                else if (gate_i[3]) q_next = 1'b1;
                else if (gate_i[0]) q_next = gate_i[1];
            end
            default: q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= 1'b0;
            g1_prev <= 1'b0;
        end else begin
            g1_prev <= gate_i[0];
            if (en && is_stateful(m)) q <= q_next;
        end
    end

    always_comb begin
        unique case (m)
            MD_ANDOR: fn_o = (gate_i[0] & gate_i[1]) | (gate_i[2] & gate_i[3]);
            MD_ORXOR: fn_o = (gate_i[0] | gate_i[1]) ^ (gate_i[2] | gate_i[3]);
            MD_AND4:  fn_o = &gate_i;
            default:  fn_o = q;
        endcase
    end

    assign q_o = q;

    // R4
    sr_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (en && m == MD_SR && (gate_i[0] || gate_i[1])) |=> q_o);

    // R5
    dff_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (m == MD_DFF_SR || m == MD_DFF2_R || m == MD_JK_R) && gate_i[2]) |=> !q_o);

    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(rst)) |=> $stable(q_o));
endmodule

// File: rtl/clc_edge_irq.sv
module clc_edge_irq (
    input  logic clk,
    input  logic rst,
    input  logic out_i,
    input  logic rise_ie,
    input  logic fall_ie,
    input  logic clr,
    output logic flag_o
);
    logic prev, hit;

    assign hit = (rise_ie & out_i & ~prev) | (fall_ie & ~out_i & prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            prev <= out_i;
            if (clr)      flag_o <= 1'b0;
            else if (hit) flag_o <= 1'b1;
        end
    end

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag_o);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr) |=> flag_o);
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import clc_pkg::*;
#(
    parameter int POOL = POOL_W,
    localparam int SW  = $clog2(POOL)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [POOL-1:0]          pool_in,
    input  logic [LANES*SW-1:0]      src_sel,
    input  logic [LANES*LANES-1:0]   gate_true,
    input  logic [LANES*LANES-1:0]   gate_comp,
    input  logic [LANES-1:0]         gate_inv,
    input  logic [2:0]               mode,
    input  logic                     cell_en,
    input  logic                     out_pol,
    input  logic                     pin_oe,
    input  logic                     rise_ie,
    input  logic                     fall_ie,
    input  logic                     flag_clr,
    output logic                     cell_out,
    output logic                     pin_out,
    output logic                     irq_flag
);
    lane_t lanes, gates;
    logic  fn, q_unused;

    clc_src_mux #(.POOL(POOL)) u_mux (
        .pool_in (pool_in),
        .src_sel (src_sel),
        .lane_o  (lanes)
    );

    clc_gate_bank u_gates (
        .lane_i    (lanes),
        .gate_true (gate_true),
        .gate_comp (gate_comp),
        .gate_inv  (gate_inv),
        .gate_o    (gates)
    );

    clc_func_core u_core (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .gate_i (gates),
        .en     (cell_en),
        .fn_o   (fn),
        .q_o    (q_unused)
    );

    assign cell_out = cell_en & (fn ^ out_pol);
    assign pin_out  = pin_oe & cell_out;

    clc_edge_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .out_i   (cell_out),
        .rise_ie (rise_ie),
        .fall_ie (fall_ie),
        .clr     (flag_clr),
        .flag_o  (irq_flag)
    );

    // R8
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        !cell_en |-> !cell_out);

    // R9
    pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_oe |-> !pin_out);
endmodule

// File: tb/sim_cfg_logic_cell.sv
`timescale 1ns/1ps
module sim_cfg_logic_cell;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pool_in;
    logic [19:0] src_sel;
    logic [15:0] gate_true, gate_comp;
    logic [3:0]  gate_inv;
    logic [2:0]  mode;
    logic        cell_en, out_pol, pin_oe, rise_ie, fall_ie, flag_clr;
    logic        cell_out, pin_out, irq_flag;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic m_q, m_g1p, m_prev, m_flag;

    always #2.5 clk = ~clk;

    cfg_logic_cell u0 (
        .clk(clk), .rst(rst), .pool_in(pool_in), .src_sel(src_sel),
        .gate_true(gate_true), .gate_comp(gate_comp), .gate_inv(gate_inv),
        .mode(mode), .cell_en(cell_en), .out_pol(out_pol), .pin_oe(pin_oe),
        .rise_ie(rise_ie), .fall_ie(fall_ie), .flag_clr(flag_clr),
        .cell_out(cell_out), .pin_out(pin_out), .irq_flag(irq_flag)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] ref_gates();
        logic [3:0] d, g;
        for (int k = 0; k < 4; k++) d[k] = pool_in[src_sel[5*k +: 5]];
        for (int gi = 0; gi < 4; gi++) begin
            g[gi] = gate_inv[gi];
            for (int k = 0; k < 4; k++)
                g[gi] = g[gi] ^ 1'b0;
            g[gi] = ((|(gate_true[4*gi +: 4] & d)) | (|(gate_comp[4*gi +: 4] & ~d))) ^ gate_inv[gi];
        end
        return g;
    endfunction

    function automatic logic ref_fn(input logic [3:0] g);
        case (mode)
            3'd0: return (g[0] & g[1]) | (g[2] & g[3]);
            3'd1: return (g[0] | g[1]) ^ (g[2] | g[3]);
            3'd2: return g[0] & g[1] & g[2] & g[3];
            default: return m_q;
        endcase
    endfunction

    function automatic logic ref_next_q(input logic [3:0] g);
        logic rise = g[0] & ~m_g1p;
        case (mode)
            3'd3: return (g[0] | g[1]) ? 1'b1 : ((g[2] | g[3]) ? 1'b0 : m_q);
            3'd4: return g[2] ? 1'b0 : g[3] ? 1'b1 : rise ? g[1] : m_q;
            3'd5: return g[2] ? 1'b0 : rise ? (g[1] ^ g[3]) : m_q;
            3'd6: begin
                if (g[2]) return 1'b0;
                if (!rise) return m_q;
                if (g[1] && g[3]) return ~m_q;
                if (g[1]) return 1'b1;
                if (g[3]) return 1'b0;
                return m_q;
            end
            3'd7: return g[2] ? 1'b0 : g[3] ? 1'b1 : g[0] ? g[1] : m_q;
            default: return m_q;
        endcase
    endfunction

    function automatic string mode_tag();
        if (!cell_en) return "R8";
        case (mode)
            3'd0, 3'd1, 3'd2: return "R3";
            3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Inputs already driven at a negedge; check, then advance the model one clock.
    task automatic step(input string tag);
        logic [3:0] g;
        logic exp_out;
        #0.5;
        g = ref_gates();
        exp_out = cell_en & (ref_fn(g) ^ out_pol);
        chk(cell_out, exp_out, (tag != "") ? tag : mode_tag());
        chk(pin_out, pin_oe & exp_out, "R9");
        chk(irq_flag, m_flag, "R10");
        @(posedge clk);
        if (flag_clr) m_flag = 1'b0;
        else if ((rise_ie & exp_out & ~m_prev) | (fall_ie & ~exp_out & m_prev)) m_flag = 1'b1;
        if (cell_en) m_q = ref_next_q(g);
        m_prev = exp_out;
        m_g1p  = g[0];
        @(negedge clk);
    endtask

    task automatic quiet();
        pool_in = '0; src_sel = '0; gate_true = '0; gate_comp = '0; gate_inv = '0;
        mode = 3'd3; cell_en = 1'b1; out_pol = 1'b0; pin_oe = 1'b1;
        rise_ie = 1'b0; fall_ie = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        quiet();
        rst = 1'b1;
        m_q = 0; m_g1p = 0; m_prev = 0; m_flag = 0;
        // Load a set bit first so reset has something to clear.
        repeat (2) @(negedge clk);
        rst = 1'b0;
        gate_true = 16'h0001; gate_comp = 16'h0001;  // gate 0 constant 1 -> set
        @(negedge clk);
        gate_true = '0; gate_comp = '0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R11
        chk(cell_out, 1'b0, "R11");
        chk(irq_flag, 1'b0, "R11");
        @(negedge clk);

        // R1: route each pool line through every lane, AND4 with own-lane gates
        mode = 3'd2; gate_true = 16'h8421; gate_comp = '0; gate_inv = '0;
        for (int i = 0; i < 32; i++) begin
            src_sel = {4{i[4:0]}};
            pool_in = 32'h1 << i;
            step("R1");
            pool_in = ~(32'h1 << i);
            step("R1");
        end
        // R1: distinct lanes, one missing line drops the output
        src_sel = {5'd31, 5'd17, 5'd9, 5'd2};
        pool_in = (32'h1 << 31) | (32'h1 << 17) | (32'h1 << 9) | 32'h4;
        step("R1");
        pool_in = pool_in & ~(32'h1 << 17);
        step("R1");

        // R2: complement term and gate inversion
        pool_in = '0; src_sel = '0; mode = 3'd2;
        gate_true = '0; gate_comp = 16'h1111; gate_inv = 4'b0000;
        step("R2");
        gate_inv = 4'b0001;
        step("R2");

        // R8: polarity with constant-one gates, then disabled with inversion
        gate_true = 16'hFFFF; gate_comp = 16'hFFFF; gate_inv = '0;
        out_pol = 1'b1;
        step("R8");
        cell_en = 1'b0;
        step("R8");
        out_pol = 1'b0; cell_en = 1'b1;
        step("R8");

        // R10: rising edge arms flag, then clear coinciding with an edge
        rise_ie = 1'b1; fall_ie = 1'b1;
        gate_true = '0; gate_comp = '0;
        step("R10");
        gate_true = 16'hFFFF; gate_comp = 16'hFFFF;
        step("R10");
        step("R10");
        gate_true = '0; gate_comp = '0; flag_clr = 1'b1;
        step("R10");
        flag_clr = 1'b0;
        step("R10");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            pool_in   = $urandom;
            src_sel   = 20'($urandom);
            gate_true = 16'($urandom & $urandom);
            gate_comp = 16'($urandom & $urandom & $urandom);
            gate_inv  = 4'($urandom);
            if (($urandom % 8) == 0) mode = 3'($urandom);
            cell_en   = ($urandom % 10) != 0;
            out_pol   = ($urandom % 4) == 0;
            pin_oe    = ($urandom % 3) != 0;
            rise_ie   = 1'($urandom);
            fall_ie   = 1'($urandom);
            flag_clr  = ($urandom % 12) == 0;
            step("");
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule